// File: doc/BRIEF.md
# Bank-Rotating SDRAM Burst Writer

This block converts a stream of data words into the command, bank, address and data sequence for a single-data-rate SDRAM with four banks. Each group of two words becomes one burst. The burst is written with a column command that also closes the row automatically. Bursts rotate over the four banks. The row activation for a later burst is issued in the gaps between column commands, so once streaming starts the data bus carries a word on every cycle. No precharge command is ever needed. A stream starts with a one-cycle start pulse that gives a base address, counted in bursts, and a length, also in bursts. Words then arrive on a valid/ready handshake.

A linear burst address is the base plus the burst index. Its two lowest bits choose the bank. The next bits give the row and the top bits give the column. Consecutive bursts therefore open many distinct rows, and ordinary traffic refreshes them as a side effect. If the upstream source runs dry in mid-stream, the block stops opening rows. It finishes the bursts whose rows are already open, with the byte masks raised for the missing words, and then goes idle. A refresh request is remembered and issued as an auto-refresh command only while the writer is idle. All banks are closed by then.

Top module: `sdram_stream_writer`

## Requirements
- R1: After reset the command is NOP ({ras_n,cas_n,we_n}=111), dq_o is zero, every dqm_o bit is 1, and ready_o and busy_o are low.
- R2: Command codes are {ras_n,cas_n,we_n}: ACT=011, WRITE=100, REF=001, NOP=111. Let cycle 0 be the first command cycle of a stream. Then burst k is activated in cycle 2k and written in cycle 2k+5. A stream therefore opens with ACT, NOP, ACT, NOP, ACT before its first WRITE.
- R3: In steady state the commands alternate every cycle. A WRITE to bank b is followed in the next cycle by an ACT to bank (b+3) mod 4 while bursts remain to be opened.
- R4: During a WRITE, addr_o[10] is 1 (auto-precharge), addr_o[COL_W-1:0] is {column,0}, and all other address bits are 0.
- R5: Burst k uses linear address L = (base_i + k) mod 2^LA_W. The bank is L[1:0], the row is L[ROW_W+1:2] and the column is the remaining upper bits. During an ACT, addr_o carries the row with zeros above it.
- R6: The j-th accepted word appears on dq_o with dqm_o all zero in cycle j+5. Words keep their acceptance order and there is no gap between beats.
- R7: No ACT follows the last burst's ACT. The closing WRITEs alternate with NOPs. busy_o falls in the cycle that shows the last data beat, and the command is NOP afterwards.
- R8: ready_o is high exactly in the cycles whose following clock edge places a word on the data bus. It is low during the start and end cycles that carry no data.
- R9: Suppose valid_i is low while ready_o is high at word s of an N-burst stream. Then that edge issues no ACT and ready_o stays low for the rest of the stream. Bursts k < min(N,(s+6)/2) are still written, with all dqm_o bits set on beats j ≥ s, and the writer then goes idle.
- R10: A refresh request is held until the writer is idle. REF is then issued on the first idle edge where no stream is being started, and busy_o stays high for RFC_CYC cycles from the REF cycle.
- R11: A start pulse with length zero, or one that arrives while busy_o is high, has no effect.
- R12: Streams of one or two bursts issue only their own ACTs and WRITEs, on the schedule of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse that begins a stream |
| base_i | input | LA_W | First linear burst address of the stream |
| len_i | input | LEN_W | Stream length in two-word bursts |
| valid_i | input | 1 | Input word present |
| data_i | input | DQ_W | Input word |
| ready_o | output | 1 | Word will be taken at the next edge |
| busy_o | output | 1 | Streaming or refreshing |
| refresh_req_i | input | 1 | Refresh request, held internally until served |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | 2 | Bank select |
| addr_o | output | A_W | Row or column address |
| dq_o | output | DQ_W | Write data |
| dqm_o | output | DQ_W/8 | Byte masks, 1 = masked |

## Verification
Uninterrupted streams of every length from one to ten bursts are run from scattered base addresses, and one longer stream wraps the linear address space. These runs separate the short-stream cases, where fewer than three banks open before the first write, from the full interleave, and they expose any wrong bank, row or column bit. A stall is then placed at every word position of a six-burst stream. Each position yields a different count of already-opened bursts and of masked beats, so an off-by-one in the drain limit shows up. Refresh is requested both in mid-stream and while idle, and start pulses of zero length or during a stream show that neither disturbs the command sequence.

// File: rtl/sdw_pkg.sv
package sdw_pkg;

  // {ras_n, cas_n, we_n}
  typedef enum logic [2:0] {
    CMD_NOP = 3'b111,
    CMD_ACT = 3'b011,
    CMD_WR  = 3'b100,
    CMD_REF = 3'b001
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_STREAM,
    ST_RFSH
  } st_e;

  localparam int AUTO_PRE_BIT = 10;

endpackage

// File: rtl/sdw_refresh.sv
module sdw_refresh (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic fire,
  output logic pend
);

  // a new request arriving on the serving edge stays pending
  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else     pend <= req | (pend & ~fire);
  end

endmodule

// File: rtl/sdw_addr.sv
module sdw_addr #(
  parameter  int ROW_W = 12,
  parameter  int COL_W = 8,
  localparam int LA_W  = ROW_W + COL_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LA_W-1:0]  base,
  input  logic             act_fire,
  input  logic             wr_fire,
  output logic [1:0]       act_bank,
  output logic [ROW_W-1:0] act_row,
  output logic [1:0]       wr_bank,
  output logic [COL_W-2:0] wr_colb
);

  logic [LA_W-1:0] act_la_q, wr_la_q;

  // separate cursors: activations run three bursts ahead of writes
  always_ff @(posedge clk) begin
    if (rst) begin
      act_la_q <= '0;
      wr_la_q  <= '0;
    end else if (load) begin
      act_la_q <= base;
      wr_la_q  <= base;
    end else begin
      if (act_fire) act_la_q <= act_la_q + LA_W'(1);
      if (wr_fire)  wr_la_q  <= wr_la_q + LA_W'(1);
    end
  end

  always_comb begin
    act_bank = act_la_q[1:0];
    act_row  = act_la_q[ROW_W+1:2];
    wr_bank  = wr_la_q[1:0];
    wr_colb  = wr_la_q[LA_W-1:ROW_W+2];
  end

endmodule

// File: rtl/sdw_sched.sv
module sdw_sched
  import sdw_pkg::*;
#(
  parameter int LEN_W   = 10,
  parameter int RFC_CYC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  input  logic             valid,
  input  logic             ref_pend,
  output logic             load,
  output logic             act_fire,
  output logic             wr_fire,
  output logic             take,
  output logic             ref_fire,
  output logic             ready,
  output logic             busy
);

  localparam int RFC_W = $clog2(RFC_CYC + 1);
  localparam int T_W   = (LEN_W + 2 > RFC_W) ? LEN_W + 2 : RFC_W;
  localparam int X_W   = T_W + 1;
  localparam logic [X_W-1:0] FIRST_BEAT = X_W'(5);
  localparam logic [X_W-1:0] TAIL       = X_W'(4);
  localparam logic [T_W-1:0] RFC_LAST   = T_W'(RFC_CYC - 1);

  st_e              st_q;
  logic [T_W-1:0]   t_q;
  logic [LEN_W-1:0] lim_q;
  logic             drain_q;

  logic [X_W-1:0] tx, limx, cutx, effx;
  logic           in_stream, beat_win, stall, last;

  // burst k: ACT at t=2k, WRITE at t=2k+5, beats at 2k+5 and 2k+6
  always_comb begin
    in_stream = (st_q == ST_STREAM);
    tx        = X_W'(t_q);
    limx      = X_W'(lim_q);
    beat_win  = in_stream && (tx >= FIRST_BEAT) && (tx < (limx << 1) + FIRST_BEAT);
    ready     = beat_win && !drain_q;
    take      = ready && valid;
    stall     = ready && !valid;
    // bursts whose ACT was issued strictly before this edge
    cutx      = (tx + X_W'(1)) >> 1;
    effx      = (stall && (cutx < limx)) ? cutx : limx;
    act_fire  = in_stream && !t_q[0] && ((tx >> 1) < effx);
    wr_fire   = in_stream && t_q[0] && (tx >= FIRST_BEAT) &&
                (((tx - FIRST_BEAT) >> 1) < effx);
    last      = in_stream && (tx == (effx << 1) + TAIL);
    load      = (st_q == ST_IDLE) && start && (len != '0);
    ref_fire  = (st_q == ST_IDLE) && !load && ref_pend;
    busy      = (st_q != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      t_q     <= '0;
      lim_q   <= '0;
      drain_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (load) begin
            st_q    <= ST_STREAM;
            t_q     <= '0;
            lim_q   <= len;
            drain_q <= 1'b0;
          end else if (ref_fire) begin
            st_q <= ST_RFSH;
            t_q  <= '0;
          end
        end
        ST_STREAM: begin
          t_q   <= t_q + T_W'(1);
          lim_q <= effx[LEN_W-1:0];
          if (stall) drain_q <= 1'b1;
          if (last)  st_q    <= ST_IDLE;
        end
        ST_RFSH: begin
          t_q <= t_q + T_W'(1);
          if (t_q == RFC_LAST) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sdram_stream_writer.sv
module sdram_stream_writer
  import sdw_pkg::*;
#(
  parameter  int DQ_W    = 16,
  parameter  int LEN_W   = 10,
  parameter  int ROW_W   = 12,
  parameter  int COL_W   = 8,
  parameter  int A_W     = 12,
  parameter  int RFC_CYC = 8,
  localparam int LA_W    = ROW_W + COL_W + 1,
  localparam int DQM_W   = DQ_W / 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [LA_W-1:0]  base_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             valid_i,
  input  logic [DQ_W-1:0]  data_i,
  output logic             ready_o,
  output logic             busy_o,
  input  logic             refresh_req_i,
  output logic             ras_n_o,
  output logic             cas_n_o,
  output logic             we_n_o,
  output logic [1:0]       ba_o,
  output logic [A_W-1:0]   addr_o,
  output logic [DQ_W-1:0]  dq_o,
  output logic [DQM_W-1:0] dqm_o
);

  if (A_W <= AUTO_PRE_BIT || COL_W > AUTO_PRE_BIT || ROW_W > A_W || COL_W < 2) begin : g_bad_geom
    $error("sdram_stream_writer: address geometry does not fit the address bus");
  end

  logic             load, act_fire, wr_fire, take, ref_fire, ref_pend;
  logic [1:0]       act_bank, wr_bank;
  logic [ROW_W-1:0] act_row;
  logic [COL_W-2:0] wr_colb;
  logic [A_W-1:0]   act_a, wr_a;

  cmd_e             cmd_q;
  logic [1:0]       ba_q;
  logic [A_W-1:0]   addr_q;
  logic [DQ_W-1:0]  dq_q;
  logic [DQM_W-1:0] dqm_q;

  sdw_sched #(.LEN_W(LEN_W), .RFC_CYC(RFC_CYC)) u_sched (
    .clk      (clk),
    .rst      (rst),
    .start    (start_i),
    .len      (len_i),
    .valid    (valid_i),
    .ref_pend (ref_pend),
    .load     (load),
    .act_fire (act_fire),
    .wr_fire  (wr_fire),
    .take     (take),
    .ref_fire (ref_fire),
    .ready    (ready_o),
    .busy     (busy_o)
  );

  sdw_addr #(.ROW_W(ROW_W), .COL_W(COL_W)) u_addr (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .base     (base_i),
    .act_fire (act_fire),
    .wr_fire  (wr_fire),
    .act_bank (act_bank),
    .act_row  (act_row),
    .wr_bank  (wr_bank),
    .wr_colb  (wr_colb)
  );

  sdw_refresh u_rfsh (
    .clk  (clk),
    .rst  (rst),
    .req  (refresh_req_i),
    .fire (ref_fire),
    .pend (ref_pend)
  );

  always_comb begin
    act_a = '0;
    act_a[ROW_W-1:0] = act_row;
    wr_a = '0;
    wr_a[COL_W-1:0] = {wr_colb, 1'b0};
    wr_a[AUTO_PRE_BIT] = 1'b1;
  end

  // ACT and WRITE land on opposite parities of the cycle count
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
      dq_q   <= '0;
      dqm_q  <= '1;
    end else begin
      if (act_fire) begin
        cmd_q  <= CMD_ACT;
        ba_q   <= act_bank;
        addr_q <= act_a;
      end else if (wr_fire) begin
        cmd_q  <= CMD_WR;
        ba_q   <= wr_bank;
        addr_q <= wr_a;
      end else if (ref_fire) begin
        cmd_q  <= CMD_REF;
        ba_q   <= '0;
        addr_q <= '0;
      end else begin
        cmd_q  <= CMD_NOP;
        ba_q   <= '0;
        addr_q <= '0;
      end
      dq_q  <= take ? data_i : '0;
      dqm_q <= take ? '0 : '1;
    end
  end

  assign {ras_n_o, cas_n_o, we_n_o} = cmd_q;
  assign ba_o   = ba_q;
  assign addr_o = addr_q;
  assign dq_o   = dq_q;
  assign dqm_o  = dqm_q;

endmodule

// File: rtl/sdw_checker.sv
module sdw_checker
  import sdw_pkg::*;
#(
  parameter int A_W  = 12,
  parameter int DQ_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [1:0]        ba,
  input logic [A_W-1:0]    addr,
  input logic [DQ_W/8-1:0] dqm,
  input logic              ready,
  input logic              valid,
  input logic              busy
);

  logic [2:0] cmd;
  assign cmd = {ras_n, cas_n, we_n};

  // R2: only the four defined command codes appear
  p_cmd_code_r2: assert property (@(posedge clk) disable iff (rst)
    cmd inside {CMD_NOP, CMD_ACT, CMD_WR, CMD_REF});

  // R4: every write closes its row
  p_auto_pre_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_WR) |-> addr[AUTO_PRE_BIT]);

  // R3: ACT after a WRITE goes three banks ahead
  p_bank_ahead_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_WR) ##1 (cmd == CMD_ACT) |-> (ba == 2'($past(ba) + 2'd3)));

  // R3: column commands never come back to back
  p_wr_spacing_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_WR) |=> (cmd != CMD_WR));

  // R6: a handshake puts unmasked data on the bus
  p_take_unmasked_r6: assert property (@(posedge clk) disable iff (rst)
    (ready && valid) |=> (dqm == '0));

  // R9: a stall opens no further row
  p_stall_no_act_r9: assert property (@(posedge clk) disable iff (rst)
    (ready && !valid) |=> (cmd != CMD_ACT));

  // R10: refresh only from idle
  p_ref_from_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_REF) |-> !$past(busy));

endmodule

bind sdram_stream_writer sdw_checker #(.A_W(A_W), .DQ_W(DQ_W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .ras_n (ras_n_o),
  .cas_n (cas_n_o),
  .we_n  (we_n_o),
  .ba    (ba_o),
  .addr  (addr_o),
  .dqm   (dqm_o),
  .ready (ready_o),
  .valid (valid_i),
  .busy  (busy_o)
);

// File: tb/sdram_stream_writer_tb_top.sv
module sdram_stream_writer_tb_top;

  localparam int DQ_W  = 16;
  localparam int LEN_W = 5;
  localparam int ROW_W = 3;
  localparam int COL_W = 3;
  localparam int A_W   = 11;
  localparam int RFC   = 4;
  localparam int LA_W  = ROW_W + COL_W + 1;
  localparam int LA_N  = 1 << LA_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_i = 1'b0;
  logic [LA_W-1:0]  base_i = '0;
  logic [LEN_W-1:0] len_i = '0;
  logic             valid_i = 1'b0;
  logic [DQ_W-1:0]  data_i = '0;
  logic             refresh_req_i = 1'b0;
  logic             ready_o, busy_o, ras_n_o, cas_n_o, we_n_o;
  logic [1:0]       ba_o;
  logic [A_W-1:0]   addr_o;
  logic [DQ_W-1:0]  dq_o;
  logic [1:0]       dqm_o;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 1'b0;

  always #2 clk = ~clk;

  sdram_stream_writer #(
    .DQ_W(DQ_W), .LEN_W(LEN_W), .ROW_W(ROW_W), .COL_W(COL_W), .A_W(A_W), .RFC_CYC(RFC)
  ) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .base_i(base_i), .len_i(len_i),
    .valid_i(valid_i), .data_i(data_i), .ready_o(ready_o), .busy_o(busy_o),
    .refresh_req_i(refresh_req_i), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o),
    .ba_o(ba_o), .addr_o(addr_o), .dq_o(dq_o), .dqm_o(dqm_o)
  );

  function automatic logic [2:0] cmd_now();
    return {ras_n_o, cas_n_o, we_n_o};
  endfunction

  function automatic logic [15:0] fword(int j, int base);
    return 16'((j * 291) ^ 23040 ^ (base * 7));
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  // one stream; s >= 0 stalls the source at word s
  task automatic run_seq(input int base, input int n, input int s, input bit want_ref, input bit poke);
    bit stl = (s >= 0);
    int L = n;
    int cnt = 0;
    bit ptake = 1'b0;
    if (stl && ((s + 6) / 2 < n)) L = (s + 6) / 2;
    @(negedge clk);
    start_i = 1'b1;
    base_i  = LA_W'(base);
    len_i   = LEN_W'(n);
    data_i  = fword(0, base);
    valid_i = !(stl && s == 0);
    for (int m = 0; m <= 2 * L + 6; m++) begin
      @(negedge clk);
      start_i = poke && (m == 8);
      if (poke && m == 8) len_i = LEN_W'(1);
      refresh_req_i = want_ref && (m == 3);
      if (ptake) cnt++;
      data_i  = fword(cnt, base);
      valid_i = !stl || (cnt < s);
      ptake   = ready_o && valid_i;
      begin
        bit exp_rdy = (m >= 5) && (m < 2 * n + 5) && (!stl || m <= s + 5);
        chk(ready_o == exp_rdy, stl ? "R9" : "R8", "ready", ready_o, exp_rdy);
      end
      if (m <= 2 * L + 5)
        chk(busy_o == (m <= 2 * L + 4), stl ? "R9" : "R7", "busy", busy_o, (m <= 2 * L + 4));
      if (m >= 1) begin
        int c = m - 1;
        int limc = (stl && c >= s + 5) ? L : n;
        logic [2:0] ec = 3'b111;
        int eba = 0;
        int ead = 0;
        int j = c - 5;
        string tg = "R7";
        if (c % 2 == 0 && c / 2 < limc) begin
          int la = (base + c / 2) % LA_N;
          ec = 3'b011; eba = la & 3; ead = (la >> 2) & ((1 << ROW_W) - 1);
          tg = (c < 5) ? "R2" : "R3";
        end else if (c % 2 == 1 && c >= 5 && (c - 5) / 2 < limc) begin
          int la = (base + (c - 5) / 2) % LA_N;
          ec = 3'b100; eba = la & 3; ead = 1024 | (((la >> (ROW_W + 2)) & 3) << 1);
          tg = "R3";
        end else if (c == 2 * L + 5 && want_ref) begin
          ec = 3'b001; tg = "R10";
        end
        if (stl) tg = "R9";
        if (n < 3) tg = "R12";
        if (poke) tg = "R11";
        chk(cmd_now() == ec, tg, "command", cmd_now(), ec);
        chk(ba_o == 2'(eba), (ec == 3'b011) ? "R5" : "R4", "bank", ba_o, eba);
        chk(addr_o == A_W'(ead), (ec == 3'b100) ? "R4" : "R5", "address", addr_o, ead);
        begin
          bit beat = (j >= 0) && (j < 2 * L) && (!stl || j < s);
          logic [15:0] ed = beat ? fword(j, base) : 16'h0;
          logic [1:0] em = beat ? 2'b00 : 2'b11;
          chk(dq_o == ed, stl ? "R9" : "R6", "dq", dq_o, ed);
          chk(dqm_o == em, stl ? "R9" : "R6", "dqm", dqm_o, em);
        end
      end
    end
    start_i = 1'b0;
    refresh_req_i = 1'b0;
    for (int w = 0; w < 20 && busy_o; w++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(cmd_now() == 3'b111, "R1", "command", cmd_now(), 3'b111);
    chk(dqm_o == 2'b11, "R1", "dqm", dqm_o, 2'b11);
    chk(dq_o == '0, "R1", "dq", dq_o, 0);
    chk(!ready_o, "R1", "ready", ready_o, 0);
    chk(!busy_o, "R1", "busy", busy_o, 0);

    // R11: zero-length start has no effect
    start_i = 1'b1; len_i = '0; base_i = LA_W'(9);
    @(negedge clk); start_i = 1'b0;
    chk(!busy_o, "R11", "busy after empty start", busy_o, 0);
    @(negedge clk);
    chk(cmd_now() == 3'b111, "R11", "command after empty start", cmd_now(), 3'b111);
    chk(!ready_o, "R11", "ready after empty start", ready_o, 0);

    // R2 R3 R4 R5 R6 R7 R8 R12: every short and medium length
    for (int n = 1; n <= 10; n++) run_seq((n * 13) % LA_N, n, -1, 1'b0, 1'b0);
    // R5: address wrap
    run_seq(125, 12, -1, 1'b0, 1'b0);
    // R9: stall at every word position
    for (int s = 0; s < 12; s++) run_seq(4 + s, 6, s, 1'b0, 1'b0);
    // R9 R12: stall in a two-burst stream
    run_seq(70, 2, 1, 1'b0, 1'b0);
    // R10 R11: refresh pending during a stream, start pulse while busy
    run_seq(0, 8, -1, 1'b1, 1'b1);

    // R10: refresh from idle
    @(negedge clk); refresh_req_i = 1'b1;
    @(negedge clk); refresh_req_i = 1'b0;
    chk(cmd_now() == 3'b111, "R10", "command before refresh", cmd_now(), 3'b111);
    @(negedge clk);
    chk(cmd_now() == 3'b001, "R10", "refresh command", cmd_now(), 3'b001);
    chk(busy_o, "R10", "busy at refresh", busy_o, 1);
    for (int k = 1; k <= RFC; k++) begin
      @(negedge clk);
      chk(cmd_now() == 3'b111, "R10", "command during refresh", cmd_now(), 3'b111);
      chk(busy_o == (k < RFC), "R10", "busy during refresh", busy_o, (k < RFC));
    end

    report();
  end

endmodule